// File: doc/BRIEF.md
# Phase-Aligned Clock Divider Fan-Out

This block picks one of two incoming clocks and derives two families of output clocks from it: a half-rate family of two copies and a quarter-rate family of six copies. A select input chooses between a differential clock pair and a single-ended clock. When both legs of the differential pair are left undriven, they settle to a known failsafe pattern (true leg 0, complement leg 1). In that state the selected clock stays at 0 instead of chattering.

The divide chain keeps the rising edges of both families aligned from reset onward. An active-low reset clears every output at once, without waiting for a clock edge. Reset release is retimed on falling edges of the selected clock, so the first output pulse after recovery is never short. The rising input edge that follows recovery raises both families together. A 100 MHz input yields 50 MHz and 25 MHz outputs.

Top module: `phase_div_fanout`

## Requirements
- R1: With `src_sel` = 0 the differential pair drives the divider; with `src_sel` = 1 the single-ended clock does. Edges on the unselected source have no effect on any output.
- R2: The differential clock is decoded as true AND NOT complement. With true held at 0 and complement at 1, the selected clock and every output stay at 0.
- R3: While `rst_n` is 0, every output reads 0. Asserting `rst_n` clears the outputs immediately, with no clock edge needed.
- R4: After `rst_n` rises, the outputs stay at 0 until `RELEASE_STAGES` falling edges of the selected clock have passed. The next rising edge drives every output to 1.
- R5: After recovery, each half-rate output inverts on every rising edge of the selected clock, giving a period of 2 input periods.
- R6: After recovery, each quarter-rate output has a period of 4 input periods with 2 periods high. It changes only on rising edges of the selected clock.
- R7: All `HALF_COPIES` half-rate outputs are identical at all times, and all `QUARTER_COPIES` quarter-rate outputs are identical at all times.
- R8: Every rising edge of the quarter-rate outputs falls on the same input edge as a rising edge of the half-rate outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_diff_t | input | 1 | Differential clock, true leg |
| clk_diff_c | input | 1 | Differential clock, complement leg |
| clk_single | input | 1 | Single-ended clock |
| src_sel | input | 1 | Source select: 0 differential, 1 single-ended |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_clk | output | HALF_COPIES | Half-rate clock copies |
| quarter_clk | output | QUARTER_COPIES | Quarter-rate clock copies |

## Verification
Reset takes effect in the same time step, so the bench samples 1 ns after it drives `rst_n` low, away from any clock edge. After release, the first `RELEASE_STAGES - 1` rising edges of the selected clock must leave the outputs at 0. From the next rising edge on, the expected pair (half, quarter) follows the sequence (1,1), (0,1), (1,0), (0,0) and repeats. The bench counts only edges of the source it selected and samples 1 ns after each of those rising edges. The two sources run at different periods, so a wrong source shows up as a broken sequence.

// File: rtl/pdf_pkg.sv
// Shared definitions for the phase-aligned divider fan-out.
// Assumes: a source select encoded as one bit, 0 = differential.
package pdf_pkg;
    typedef enum logic {
        SRC_DIFF   = 1'b0,
        SRC_SINGLE = 1'b1
    } src_e;
endpackage

// File: rtl/pdf_clk_source.sv
// Source selection with failsafe differential decode.
// The differential leg pair is reduced to true AND NOT complement, so an
// undriven pair (true 0, complement 1) gives a steady 0.
// Assumes: src_sel only changes while the block is held in reset.
module pdf_clk_source
    import pdf_pkg::*;
(
    input  logic clk_diff_t,
    input  logic clk_diff_c,
    input  logic clk_single,
    input  logic src_sel,
    output logic clk_sel
);
    logic diff_clk;
    src_e src;

    // Decode the differential pair; failsafe pattern yields 0.
    assign diff_clk = clk_diff_t & ~clk_diff_c;
    assign src      = src_e'(src_sel);

    // Route the chosen source to the divider.
    always_comb begin
        case (src)
            SRC_SINGLE: clk_sel = clk_single;
            default:    clk_sel = diff_clk;
        endcase
    end
endmodule

// File: rtl/pdf_release_sync.sv
// Reset recovery retimer: asserts asynchronously, releases after
// STAGES falling edges of the selected clock.
// Assumes: STAGES >= 1.
module pdf_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    output logic run_n
);
    logic [STAGES-1:0] chain_q;

    // Shift a one through the chain on falling edges; clear at once on reset.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= 1'b1;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign run_n = chain_q[STAGES-1];
endmodule

// File: rtl/pdf_div_chain.sv
// Divide-by-two and divide-by-four state, both on the same input edge.
// The quarter stage inverts only on edges where the half stage rises, so
// both stages rise together.
// Assumes: run_n is released away from rising edges of clk.
module pdf_div_chain (
    input  logic clk,
    input  logic run_n,
    output logic half_q,
    output logic quarter_q
);
    // Advance both divider stages; clear them at once while run_n is low.
    always_ff @(posedge clk or negedge run_n) begin
        if (!run_n) begin
            half_q    <= 1'b0;
            quarter_q <= 1'b0;
        end else begin
            half_q <= ~half_q;
            if (!half_q) begin
                quarter_q <= ~quarter_q;
            end
        end
    end
endmodule

// File: rtl/pdf_fanout.sv
// Replicates one divider bit onto COPIES identical output lines.
// Assumes: COPIES >= 1.
module pdf_fanout #(
    parameter int COPIES = 2
) (
    input  logic              src,
    output logic [COPIES-1:0] copies
);
    // One buffer per copy, all fed from the same flop.
    for (genvar g = 0; g < COPIES; g++) begin : g_copy
        assign copies[g] = src;
    end
endmodule

// File: rtl/phase_div_fanout.sv
// Top: source select, reset retiming, aligned divide chain and fan-out.
// Assumes: src_sel changes only while rst_n is low.
module phase_div_fanout #(
    parameter int HALF_COPIES    = 2,
    parameter int QUARTER_COPIES = 6,
    parameter int RELEASE_STAGES = 2
) (
    input  logic                      clk_diff_t,
    input  logic                      clk_diff_c,
    input  logic                      clk_single,
    input  logic                      src_sel,
    input  logic                      rst_n,
    output logic [HALF_COPIES-1:0]    half_clk,
    output logic [QUARTER_COPIES-1:0] quarter_clk
);
    logic sel_clk;
    logic run_n;
    logic half_q;
    logic quarter_q;

    pdf_clk_source u_src (
        .clk_diff_t (clk_diff_t),
        .clk_diff_c (clk_diff_c),
        .clk_single (clk_single),
        .src_sel    (src_sel),
        .clk_sel    (sel_clk)
    );

    pdf_release_sync #(.STAGES(RELEASE_STAGES)) u_rel (
        .clk   (sel_clk),
        .rst_n (rst_n),
        .run_n (run_n)
    );

    pdf_div_chain u_div (
        .clk       (sel_clk),
        .run_n     (run_n),
        .half_q    (half_q),
        .quarter_q (quarter_q)
    );

    pdf_fanout #(.COPIES(HALF_COPIES)) u_half_fan (
        .src    (half_q),
        .copies (half_clk)
    );

    pdf_fanout #(.COPIES(QUARTER_COPIES)) u_quarter_fan (
        .src    (quarter_q),
        .copies (quarter_clk)
    );
endmodule

// File: rtl/pdf_checker.sv
// Property checker for phase_div_fanout, attached by bind below.
module pdf_checker #(
    parameter int HALF_COPIES    = 2,
    parameter int QUARTER_COPIES = 6
) (
    input logic                      clk_sel,
    input logic                      rst_n,
    input logic                      run_n,
    input logic [HALF_COPIES-1:0]    half_clk,
    input logic [QUARTER_COPIES-1:0] quarter_clk
);
    // R7: copies inside each family agree.
    p_copies_agree_r7: assert property (@(posedge clk_sel) disable iff (!rst_n)
        (($countones(half_clk) == 0) || ($countones(half_clk) == HALF_COPIES)) &&
        (($countones(quarter_clk) == 0) || ($countones(quarter_clk) == QUARTER_COPIES)));

    // R5: once running, the half-rate output inverts every rising edge.
    p_half_toggles_r5: assert property (@(posedge clk_sel) disable iff (!rst_n)
        $past(run_n) |-> (half_clk[0] != $past(half_clk[0])));

    // R8: a quarter-rate rise comes with a half-rate rise.
    p_quarter_aligned_r8: assert property (@(posedge clk_sel) disable iff (!rst_n)
        $rose(quarter_clk[0]) |-> $rose(half_clk[0]));

    // R6: quarter-rate output never changes when half-rate output falls.
    p_quarter_hold_r6: assert property (@(posedge clk_sel) disable iff (!rst_n)
        $fell(half_clk[0]) |-> $stable(quarter_clk[0]));

    // R3: outputs read 0 at any clock edge seen during reset.
    always @(posedge clk_sel) begin
        if (!rst_n) begin
            p_reset_zero_r3: assert (half_clk == '0 && quarter_clk == '0);
        end
    end
endmodule

bind phase_div_fanout pdf_checker #(
    .HALF_COPIES    (HALF_COPIES),
    .QUARTER_COPIES (QUARTER_COPIES)
) u_chk (
    .clk_sel     (sel_clk),
    .rst_n       (rst_n),
    .run_n       (run_n),
    .half_clk    (half_clk),
    .quarter_clk (quarter_clk)
);

// File: tb/phase_div_fanout_test.sv
module phase_div_fanout_test;
    localparam int HC = 2;
    localparam int QC = 6;
    localparam int RS = 2;

    logic clk_single = 1'b0;
    logic diff_raw   = 1'b0;
    logic diff_en    = 1'b1;
    logic src_sel    = 1'b1;
    logic rst_n      = 1'b0;
    logic clk_diff_t, clk_diff_c;
    logic [HC-1:0] half_clk;
    logic [QC-1:0] quarter_clk;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk_single = ~clk_single;
    always #7 diff_raw = ~diff_raw;
    assign clk_diff_t = diff_en ? diff_raw  : 1'b0;
    assign clk_diff_c = diff_en ? ~diff_raw : 1'b1;

    phase_div_fanout #(.HALF_COPIES(HC), .QUARTER_COPIES(QC), .RELEASE_STAGES(RS)) uut (
        .clk_diff_t (clk_diff_t),
        .clk_diff_c (clk_diff_c),
        .clk_single (clk_single),
        .src_sel    (src_sel),
        .rst_n      (rst_n),
        .half_clk   (half_clk),
        .quarter_clk(quarter_clk)
    );

    // Expected value after the n-th rising edge since recovery (n from 0).
    function automatic logic exp_half(int n);
        return (n % 2) == 0;
    endfunction
    function automatic logic exp_quarter(int n);
        return (n % 4) < 2;
    endfunction

    task automatic check(string req, logic [HC-1:0] h_exp, logic [QC-1:0] q_exp);
        checks++;
        if (half_clk !== h_exp || quarter_clk !== q_exp) begin
            errors++;
            $display("FAIL %s: half=%b quarter=%b expected half=%b quarter=%b",
                     req, half_clk, quarter_clk, h_exp, q_exp);
        end
    endtask

    task automatic wait_rise();
        if (src_sel) @(posedge clk_single);
        else         @(posedge clk_diff_t);
    endtask

    // Reset, choose source, release just after a rising edge, then
    // follow the divided pattern for n_edges rising edges.
    task automatic run_trial(logic sel, int hold, int n_edges, string req);
        rst_n = 1'b0;
        #1;
        check("R3", '0, '0);
        src_sel = sel;
        repeat (hold) wait_rise();
        #1;
        check("R3", '0, '0);
        wait_rise();
        #1;
        rst_n = 1'b1;
        repeat (RS - 1) begin
            wait_rise();
            #1;
            check("R4", '0, '0);
        end
        for (int n = 0; n < n_edges; n++) begin
            wait_rise();
            #1;
            check(n == 0 ? "R4" : req, {HC{exp_half(n)}}, {QC{exp_quarter(n)}});
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0642));
        // R1, R5, R6, R7, R8: single-ended source while differential runs.
        run_trial(1'b1, 3, 16, "R5 R6 R7 R8");
        // R1: differential source while single-ended runs at another rate.
        run_trial(1'b0, 2, 16, "R1");
        // R3: asynchronous reset between edges.
        wait_rise();
        #3;
        rst_n = 1'b0;
        #1;
        check("R3 async", '0, '0);
        // R2: undriven differential pair gives no activity.
        diff_en = 1'b0;
        src_sel = 1'b0;
        #20;
        rst_n = 1'b1;
        #200;
        check("R2", '0, '0);
        rst_n = 1'b0;
        diff_en = 1'b1;
        #20;
        // Random mix of sources, reset lengths and run lengths.
        for (int t = 0; t < 12; t++) begin
            automatic logic s = 1'($urandom_range(0, 1));
            automatic int h = $urandom_range(1, 6);
            automatic int k = $urandom_range(8, 40);
            run_trial(s, h, k, s ? "R6" : "R1");
        end
        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule